// File: doc/BRIEF.md
# Hysteretic Dual-Duty Synchronous Gate Generator

This block drives the two switches of a synchronous step-down stage. A free-running period counter makes a base square wave. A single feedback bit from an external comparator picks one of two fixed duty cycles. When the bit says the output voltage has fallen below the lower threshold, the block uses a high-duty waveform; otherwise it uses a low-duty one. This is bang-bang hysteretic regulation.

Each of the two candidate waveforms, S, is combined with a delayed copy of itself, S'. The high-side gate is S AND S' and the low-side gate is NOR(S, S'). This inserts a dead gap at every edge, so the delay also shortens the high-side on-time. The low-duty path takes the base wave (high while the count is below the threshold) with a longer delay. The high-duty path takes the inverse of the base wave with a shorter delay.

The feedback bit is synchronized. The duty choice is latched only at counter wrap, so the choice never changes in the middle of a period. After reset, both gates stay low for the whole first period.

Top module: `hyst_pwm_gen`

## Requirements
- R1: The period counter counts 0 to PERIOD-1 and wraps, so both gate waveforms repeat every PERIOD cycles (default 60).
- R2: With `fb_below`=0 held, each period has the high-side gate high for THRESH-DLY_LO cycles and the low-side gate high for PERIOD-THRESH-DLY_LO cycles (defaults: 12 and 42).
- R3: With `fb_below`=1 held, each period has the high-side gate high for PERIOD-THRESH-DLY_HI cycles and the low-side gate high for THRESH-DLY_HI cycles (defaults: 43 and 13).
- R4: `hs_gate` and `ls_gate` are never high in the same cycle.
- R5: Between any high run of one gate and the next high run of the other gate, both gates are low for exactly the active path's delay: DLY_LO (3) on the low-duty path or DLY_HI (2) on the high-duty path.
- R6: The duty selection changes only at counter wrap. Every high run therefore has the full length of one path: the high-side run is 12 or 43 cycles and the low-side run is 42 or 13 cycles, even when `fb_below` toggles at any phase.
- R7: While `rst_n` is low, and for the first PERIOD cycles after reset is released, both gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_below | input | 1 | Comparator bit: 1 means the output is below the lower threshold |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side switch enable |

## Verification
The assertions assume that `fb_below` may change at any cycle, but that it stays at one level long enough to pass the two-flop synchronizer before the next wrap is judged. The assertions also assume that reset is held for several cycles at the start. The stimulus flips the feedback bit at phases that sweep across the whole period. After each flip it holds the bit for several periods, so every steady-state window has a single, known selection. Run-length checks also cover the periods in which the selection switches.

// File: rtl/hyst_pwm_gen.sv
module hyst_pwm_gen #(
  parameter int PERIOD = 60,
  parameter int THRESH = 15,
  parameter int DLY_LO = 3,
  parameter int DLY_HI = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_below,
  output logic hs_gate,
  output logic ls_gate
);
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0]     cnt;
  logic              wrap, sq;
  logic              fb_s1, fb_s2, sel_hi, armed;
  logic [DLY_LO-1:0] dlo;
  logic [DLY_HI-1:0] dhi;
  logic              lo_hs, lo_ls, hi_hs, hi_ls;

  assign wrap = (cnt == CW'(PERIOD - 1));
  assign sq   = (cnt < CW'(THRESH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      fb_s1  <= 1'b0;
      fb_s2  <= 1'b0;
      sel_hi <= 1'b0;
      armed  <= 1'b0;
      dlo    <= '0;
      dhi    <= '0;
    end else begin
      cnt   <= wrap ? '0 : cnt + 1'b1;
      fb_s1 <= fb_below;
      fb_s2 <= fb_s1;
      if (wrap) begin
        sel_hi <= fb_s2;
        armed  <= 1'b1;
      end
      dlo[0] <= sq;
      for (int i = 1; i < DLY_LO; i++) dlo[i] <= dlo[i-1];
      dhi[0] <= ~sq;
      for (int i = 1; i < DLY_HI; i++) dhi[i] <= dhi[i-1];
    end
  end

  assign lo_hs = sq & dlo[DLY_LO-1];
  assign lo_ls = ~(sq | dlo[DLY_LO-1]);
  assign hi_hs = ~sq & dhi[DLY_HI-1];
  assign hi_ls = ~(~sq | dhi[DLY_HI-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_gate <= 1'b0;
      ls_gate <= 1'b0;
    end else begin
      hs_gate <= armed & (sel_hi ? hi_hs : lo_hs);
      ls_gate <= armed & (sel_hi ? hi_ls : lo_ls);
    end
  end
endmodule

// File: rtl/hyst_pwm_chk.sv
module hyst_pwm_chk #(
  parameter int PERIOD = 60,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          sel_hi,
  input logic          armed,
  input logic          hs_gate,
  input logic          ls_gate
);
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(PERIOD - 1)) |=> (cnt == '0));
  a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < CW'(PERIOD)));
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));
  a_r5_gap_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_gate) |-> !ls_gate);
  a_r5_gap_after_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_gate) |-> !hs_gate);
  a_r6_sel_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi != $past(sel_hi)) |-> (cnt == '0));
  a_r7_quiet_first: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!hs_gate && !ls_gate));
endmodule

bind hyst_pwm_gen hyst_pwm_chk #(.PERIOD(PERIOD), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .sel_hi(sel_hi), .armed(armed),
  .hs_gate(hs_gate), .ls_gate(ls_gate)
);

// File: tb/tb_hyst_pwm_gen.sv
module tb_hyst_pwm_gen;
  localparam int P = 60, T = 15, DL = 3, DH = 2;
  localparam int LO_HS = T - DL, LO_LS = P - T - DL;
  localparam int HI_HS = P - T - DH, HI_LS = T - DH;

  logic clk = 0, rst_n = 0, fb_below = 0;
  logic hs_gate, ls_gate;
  int total = 0, bad = 0, overlaps = 0;

  hyst_pwm_gen #(.PERIOD(P), .THRESH(T), .DLY_LO(DL), .DLY_HI(DH)) dut (
    .clk(clk), .rst_n(rst_n), .fb_below(fb_below),
    .hs_gate(hs_gate), .ls_gate(ls_gate));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run-length monitor: R4, R5, R6
  logic [1:0] pst = 2'b00;
  int run = 0;
  bit started = 0, mon_on = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (hs_gate && ls_gate) overlaps++;
      if ({hs_gate, ls_gate} == pst) run++;
      else begin
        if (started) begin
          case (pst)
            2'b10: chk(run == LO_HS || run == HI_HS, "R6 hs run", run, LO_HS);
            2'b01: chk(run == LO_LS || run == HI_LS, "R6 ls run", run, LO_LS);
            2'b00: chk(run == DL || run == DH, "R5 gap", run, DL);
            default: ;
          endcase
        end else started = 1;
        pst = {hs_gate, ls_gate};
        run = 1;
      end
    end
  end

  task automatic measure(input int exp_hs, input int exp_ls, input string req);
    int nh = 0, nl = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      nh += int'(hs_gate);
      nl += int'(ls_gate);
    end
    chk(nh == exp_hs, {req, " hs count"}, nh, exp_hs);
    chk(nl == exp_ls, {req, " ls count"}, nl, exp_ls);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!hs_gate && !ls_gate, "R7 in reset", {hs_gate, ls_gate}, 0);
    rst_n = 1;
    begin
      int seen = 0;
      for (int i = 0; i < P; i++) begin
        @(negedge clk);
        seen += int'(hs_gate | ls_gate);
      end
      chk(seen == 0, "R7 first period quiet", seen, 0);
    end
    mon_on = 1;
    repeat (2 * P) @(negedge clk);
    measure(LO_HS, LO_LS, "R2 R1");
    fb_below = 1;
    repeat (3 * P) @(negedge clk);
    measure(HI_HS, HI_LS, "R3 R1");
    // sweep flip phase over the period
    for (int ph = 0; ph < P; ph += 7) begin
      repeat (ph) @(negedge clk);
      fb_below = ~fb_below;
      repeat (3 * P) @(negedge clk);
      if (fb_below) measure(HI_HS, HI_LS, "R3 sweep");
      else measure(LO_HS, LO_LS, "R2 sweep");
    end
    // short glitches at odd phases
    for (int ph = 1; ph < P; ph += 11) begin
      repeat (ph) @(negedge clk);
      fb_below = ~fb_below;
      repeat (5) @(negedge clk);
      fb_below = ~fb_below;
    end
    repeat (3 * P) @(negedge clk);
    chk(overlaps == 0, "R4 overlap cycles", overlaps, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule